// File: doc/BRIEF.md
# Reversible Binary Counter with Asynchronous Preset

This block is a synchronous up/down binary counter built from one or more 4-bit stages. All stages share one clock. On each rising edge the whole value moves by one when the active-low count enable is low. A single direction input chooses between increment and decrement. An active-low preset input copies a parallel data word into the register at once, without waiting for a clock edge. This lets the counter act as a programmable modulo-N divider.

Each stage decodes a terminal-count condition that depends on direction. The condition is the all-ones value when counting up and zero when counting down. Each stage also drives an active-low carry pulse that is asserted only during the low half of the clock, so that it can feed the next stage as an enable or as a clock. Inside the block, stage k advances only when every lower stage sits at its terminal count. The chain therefore behaves as one wide counter. A synchronous active-high reset clears the value.

Top module: `rc_chain`

## Requirements
- R1: With `cnt_en_n` low, `dir_down` low and `load_n` high, each rising clock edge increments `value` by one, modulo 2^(STAGE_W*STAGES) (all ones wraps to 0).
- R2: With `cnt_en_n` low, `dir_down` high and `load_n` high, each rising clock edge decrements `value` by one, modulo 2^(STAGE_W*STAGES) (0 wraps to all ones).
- R3: With `cnt_en_n` high, `value` keeps its contents across clock edges.
- R4: A low level on `load_n` sets `value` to `preset` within the same clock phase, with no clock edge needed. A rising edge that arrives while `load_n` is low loads `preset` again, which overrides both counting and `rst`.
- R5: `rst` high at a rising edge (with `load_n` high) clears `value` to 0 at that edge.
- R6: `term_cnt` is high exactly when `dir_down` is high and `value` is 0, or when `dir_down` is low and `value` is all ones. It follows a change of `value` or `dir_down` without waiting for a clock edge.
- R7: `stage_ripple_n[k]` is high whenever `clk` is high. While `clk` is low, it is low exactly when stage k is at its own terminal count (for a 4-bit stage: nibble 0 when down, nibble 15 when up), `cnt_en_n` is low, and every stage below k is at its terminal count.
- R8: Changes of `cnt_en_n` or `dir_down` between clock edges leave `value` unchanged until the next rising edge.
- R9: Stage k (k>0) advances only on edges where all lower stages are at terminal count, so that two 4-bit stages count 0..255 and back as one 8-bit counter. Bits [4k+3:4k] of `value`, `preset` and `stage_ripple_n[k]` belong to stage k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low asynchronous preset |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| preset | input | STAGE_W*STAGES | Parallel preset data |
| value | output | STAGE_W*STAGES | Counter contents |
| term_cnt | output | 1 | Whole-chain terminal count for the current direction |
| stage_ripple_n | output | STAGES | Per-stage active-low carry, low-phase gated |

## Verification
The bench builds the block twice. The first instance has the default STAGE_W=4, STAGES=2. This brings a full up sweep and a full down sweep over all 256 values within reach, every carry between the two nibbles, and an exhaustive terminal-count decode in both directions. The second instance uses STAGES=1. It runs on the same stimulus as a lone 4-bit stage and gives the preset-to-13 count-up, inhibit and count-down sequence with wrap at 15 and 0. Both instances see presets in both clock phases, presets held across edges, and reset contending with preset.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/rc_tc_decode.sv
module rc_tc_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  input  logic         dir_down,
  output logic         tc
);
  import rc_pkg::*;
  dir_e dir;
  always_comb begin
    dir = dir_e'(dir_down);
    if (dir == DIR_DOWN) tc = (val == '0);
    else                 tc = (val == {W{1'b1}});
  end
endmodule

// File: rtl/rc_stage.sv
module rc_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         en_n,
  input  logic         dir_down,
  input  logic [W-1:0] preset,
  output logic [W-1:0] value,
  output logic         tc,
  output logic         ripple_n
);
  import rc_pkg::*;
  logic [W-1:0] cnt;
  dir_e         dir;

  assign dir = dir_e'(dir_down);

  // preset has priority over clear and counting; clear is synchronous
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)    cnt <= preset;
    else if (rst)   cnt <= '0;
    else if (!en_n) cnt <= (dir == DIR_DOWN) ? cnt - W'(1) : cnt + W'(1);
  end

  rc_tc_decode #(.W(W)) u_tc (
    .val      (cnt),
    .dir_down (dir_down),
    .tc       (tc)
  );

  // carry pulse: enabled terminal count, shown only in the clock-low phase
  assign ripple_n = ~(tc & ~en_n & ~clk);
  assign value    = cnt;
endmodule

// File: rtl/rc_chain.sv
module rc_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_n,
  input  logic                        cnt_en_n,
  input  logic                        dir_down,
  input  logic [STAGE_W*STAGES-1:0]   preset,
  output logic [STAGE_W*STAGES-1:0]   value,
  output logic                        term_cnt,
  output logic [STAGES-1:0]           stage_ripple_n
);
  localparam int TOTAL_W = STAGE_W * STAGES;

  logic [STAGES:0]   lower_tc;   // lower_tc[k]: all stages below k at terminal count
  logic [STAGES-1:0] stage_tc;
  logic [STAGES-1:0] stage_en_n;

  assign lower_tc[0] = 1'b1;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign stage_en_n[k] = cnt_en_n | ~lower_tc[k];
    assign lower_tc[k+1] = lower_tc[k] & stage_tc[k];

    rc_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load_n   (load_n),
      .en_n     (stage_en_n[k]),
      .dir_down (dir_down),
      .preset   (preset[k*STAGE_W +: STAGE_W]),
      .value    (value[k*STAGE_W +: STAGE_W]),
      .tc       (stage_tc[k]),
      .ripple_n (stage_ripple_n[k])
    );
  end

  assign term_cnt = lower_tc[STAGES];

  if (TOTAL_W < 1) begin : g_bad_cfg
    initial $error("rc_chain: empty configuration");
  end
endmodule

// File: rtl/rc_chain_chk.sv
module rc_chain_chk #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      load_n,
  input logic                      cnt_en_n,
  input logic                      dir_down,
  input logic [STAGE_W*STAGES-1:0] value,
  input logic                      term_cnt,
  input logic [STAGES-1:0]         stage_ripple_n
);
  localparam int TW = STAGE_W * STAGES;

  // set by any preset activity since the previous rising edge
  logic ld_seen;
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) ld_seen <= 1'b1;
    else         ld_seen <= 1'b0;
  end

  p_up_r1: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_n && !dir_down && load_n) |=> (ld_seen || value == TW'($past(value) + TW'(1))));

  p_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_n && dir_down && load_n) |=> (ld_seen || value == TW'($past(value) - TW'(1))));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en_n && load_n) |=> (ld_seen || value == $past(value)));

  p_tc_decode_r6: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (dir_down ? (value == '0) : (value == {TW{1'b1}})));

  p_ripple_low_r7: assert property (@(posedge clk) disable iff (rst)
    stage_ripple_n[STAGES-1] == !(term_cnt && !cnt_en_n));

  p_ripple_high_r7: assert property (@(negedge clk) disable iff (rst)
    stage_ripple_n == {STAGES{1'b1}});
endmodule

bind rc_chain rc_chain_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .load_n         (load_n),
  .cnt_en_n       (cnt_en_n),
  .dir_down       (dir_down),
  .value          (value),
  .term_cnt       (term_cnt),
  .stage_ripple_n (stage_ripple_n)
);

// File: tb/tb_rc_chain.sv
module tb_rc_chain;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       en_n = 1'b1;
  logic       dir = 1'b0;
  logic [7:0] preset = 8'd0;
  logic [7:0] value;
  logic       tc;
  logic [1:0] rip;
  logic [3:0] v1;
  logic       tc1;
  logic [0:0] rip1;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m = 8'd0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rc_chain dut (
    .clk(clk), .rst(rst), .load_n(load_n), .cnt_en_n(en_n), .dir_down(dir),
    .preset(preset), .value(value), .term_cnt(tc), .stage_ripple_n(rip)
  );

  rc_chain #(.STAGE_W(4), .STAGES(1)) u_one (
    .clk(clk), .rst(rst), .load_n(load_n), .cnt_en_n(en_n), .dir_down(dir),
    .preset(preset[3:0]), .value(v1), .term_cnt(tc1), .stage_ripple_n(rip1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit tcn(input logic [3:0] n, input bit d);
    return d ? (n == 4'd0) : (n == 4'd15);
  endfunction

  // low-phase check: value, decode and carries (R6, R7, R8)
  task automatic low_checks();
    bit t0, t1, e0, e1;
    t0 = tcn(m[3:0], dir);
    t1 = tcn(m[7:4], dir);
    e0 = !(t0 && !en_n);
    e1 = !(t1 && t0 && !en_n);
    chk(value == m, "R8 value steady between edges", value, m);
    chk(tc == (dir ? (m == 8'd0) : (m == 8'd255)), "R6 chain term_cnt", tc, dir ? (m == 0) : (m == 255));
    chk(rip[0] == e0, "R7 stage0 ripple low phase", rip[0], e0);
    chk(rip[1] == e1, "R7 stage1 ripple low phase", rip[1], e1);
    chk(v1 == m[3:0], "R9 single stage value", v1, m[3:0]);
    chk(tc1 == t0, "R6 single stage term_cnt", tc1, t0);
    chk(rip1[0] == e0, "R7 single stage ripple", rip1[0], e0);
  endtask

  // one clock cycle, entered and left at negedge+1
  task automatic cyc();
    #1;
    low_checks();
    @(posedge clk);
    if (!load_n)    m = preset;
    else if (rst)   m = 8'd0;
    else if (!en_n) m = dir ? m - 8'd1 : m + 8'd1;
    #2;
    chk(value == m, "R1 R2 R3 R5 value after edge", value, m);
    chk(rip == 2'b11 && rip1 == 1'b1, "R7 ripple high in high phase", {rip, rip1}, 7);
    @(negedge clk);
    #1;
  endtask

  // preset pulse while clk is low
  task automatic load_lo(input logic [7:0] v);
    preset = v;
    load_n = 1'b0;
    #1;
    chk(value == v, "R4 async preset in low phase", value, v);
    load_n = 1'b1;
    m = v;
    #1;
  endtask

  initial begin
    en_n = 1'b1; dir = 1'b0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(value == 8'd0 && v1 == 4'd0, "R5 reset state", value, 0);
    m = 8'd0;
    rst = 1'b0;

    // reference sequence on the single stage (low nibble)
    load_lo(8'd13);
    chk(v1 == 4'd13, "R4 preset 13", v1, 13);
    en_n = 1'b0; dir = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(v1 == 4'((14 + i) % 16), "R1 up sequence", v1, (14 + i) % 16);
      if (v1 == 4'd15) chk(tc1, "R6 terminal at 15 up", tc1, 1);
    end
    en_n = 1'b1;
    repeat (2) cyc();
    chk(v1 == 4'd2, "R3 inhibit holds", v1, 2);
    // R8: direction flips in low phase, value must not move
    dir = 1'b1; en_n = 1'b0;
    #1;
    chk(v1 == 4'd2, "R8 control change no effect", v1, 2);
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(v1 == 4'((17 - i) % 16), "R2 down sequence", v1, (17 - i) % 16);
      if (v1 == 4'd0) chk(tc1, "R6 terminal at 0 down", tc1, 1);
    end

    // R9 full two-stage sweep up and down
    en_n = 1'b1; dir = 1'b0;
    load_lo(8'd0);
    en_n = 1'b0;
    for (int i = 0; i < 256; i++) cyc();
    chk(value == 8'd0, "R9 R1 chain wraps 255->0", value, 0);
    dir = 1'b1;
    for (int i = 0; i < 256; i++) cyc();
    chk(value == 8'd0, "R9 R2 chain wraps back to 0", value, 0);

    // R6 exhaustive decode with counting inhibited
    en_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      for (int d = 0; d < 2; d++) begin
        dir = d[0];
        load_lo(8'(v));
        cyc();
      end
    end

    // R4 preset during high phase
    en_n = 1'b0; dir = 1'b0;
    @(posedge clk);
    m = m + 8'd1;
    #2;
    preset = 8'hA5; load_n = 1'b0;
    #1;
    chk(value == 8'hA5, "R4 async preset in high phase", value, 8'hA5);
    load_n = 1'b1; m = 8'hA5;
    @(negedge clk); #1;
    cyc();
    chk(value == 8'hA6, "R1 count after high-phase preset", value, 8'hA6);

    // R4 preset held across an edge overrides counting and reset
    preset = 8'h3C; load_n = 1'b0; m = 8'h3C;
    cyc();
    chk(value == 8'h3C, "R4 held preset beats counting", value, 8'h3C);
    rst = 1'b1;
    cyc();
    chk(value == 8'h3C, "R4 held preset beats reset", value, 8'h3C);
    load_n = 1'b1;
    cyc();
    chk(value == 8'd0, "R5 reset clears while enabled", value, 0);
    rst = 1'b0;

    // R3 enable toggling mid-run
    dir = 1'b1;
    load_lo(8'h10);
    cyc();
    chk(value == 8'h0F, "R9 borrow into upper stage", value, 8'h0F);
    en_n = 1'b1;
    cyc();
    chk(value == 8'h0F, "R3 disabled holds", value, 8'h0F);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule